// File: doc/BRIEF.md
# Delayed Read Transaction Engine

This block converts every read that arrives on the initiator side of a bus bridge into a delayed transaction. When the address phase is seen, the block latches the address, command and address parity. When the initiator signals a ready data phase, it also takes the first byte enables. The request goes into a small slot queue, and the initiator is told to retry. The initiator then keeps presenting the same read. It is told to retry again until the queued slot has finished. It then receives an acknowledge, or an acknowledge with an abort flag, and the slot is freed.

On the target side, slots are replayed strictly in capture order. A slot may not start while any posted write that was queued ahead of it is still outstanding. The replay master requests the target bus and drives the address phase in the cycle after grant. The data phases follow, with byte enables chosen by whether the read is prefetchable. The master then handles the target's wait, data, disconnect, retry and abort answers. The target data itself, the arbitration and the error reporting are outside the block. They appear as single-wire handshakes.

Top module: `dly_read_engine`

## Requirements
- R1: A read command (I/O read 0x2, memory read 0x6, configuration read 0xA, memory read multiple 0xC, memory read line 0xE), presented with `ini_start` and later `ini_irdy`, is stored in a free slot. It is answered with a one-cycle `ini_retry` in the cycle after `ini_irdy`. `ini_retry` and `ini_ack` are never high together.
- R2: Any other command code produces neither `ini_retry` nor `ini_ack`, and it causes no target-side activity.
- R3: A repeated read whose address and command match an unfinished slot gets `ini_retry` again. No second slot or replay is created.
- R4: A slot's replay does not start while any posted write counted before or at its capture (`pw_push` minus `pw_pop`) is outstanding. Writes pushed later do not hold it back.
- R5: The replay holds `tgt_req` until `tgt_gnt`. In the cycle after grant, it drives one address phase with exactly the captured address, command and parity.
- R6: A non-prefetchable replay drives a single data phase in the cycle after the address phase. That phase carries the captured byte enables and has `tgt_last` high.
- R7: Memory read line and memory read multiple are always prefetchable. A memory read is prefetchable when `ini_pref` was high at the address phase. I/O and configuration reads never are. A prefetchable replay drives byte enables 0 on every data phase and bursts BURST transfers, with `tgt_last` high only on the final phase.
- R8: A target retry (`tgt_rsp`=3) before any transfer ends the attempt. The master re-requests the bus and repeats the same read, with no limit on the number of attempts.
- R9: The slot is complete, with no further attempts, in each of three cases: the last planned transfer (`tgt_rsp`=1), a disconnect with data (`tgt_rsp`=2), or a retry after at least one transfer. Each transfer pulses `rd_push`. The next matching initiator read gets `ini_ack` with `ini_abort` low.
- R10: With every slot occupied, a non-matching read gets `ini_retry` and is not stored.
- R11: A target abort (`tgt_rsp`=4) or master abort (`tgt_rsp`=5) ends the replay. The next matching read gets `ini_ack` together with `ini_abort`.
- R12: Slots are replayed in the order they were captured.
- R13: An acknowledged slot is freed, so the same read presented again is stored as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ini_start | input | 1 | Initiator address phase strobe |
| ini_addr | input | AW | Initiator read address |
| ini_cmd | input | 4 | Initiator bus command |
| ini_par | input | 1 | Initiator address parity |
| ini_pref | input | 1 | Address lies in prefetchable space |
| ini_irdy | input | 1 | Initiator first data phase ready |
| ini_be | input | 4 | First data phase byte enables |
| ini_retry | output | 1 | Terminate the initiator with retry |
| ini_ack | output | 1 | Completed read handed to the initiator |
| ini_abort | output | 1 | Completed read ended with an abort |
| pw_push | input | 1 | A posted write entered the write queue |
| pw_pop | input | 1 | A posted write was delivered |
| tgt_req | output | 1 | Target bus request |
| tgt_gnt | input | 1 | Target bus grant |
| tgt_addr_vld | output | 1 | Target address phase |
| tgt_addr | output | AW | Replayed address |
| tgt_cmd | output | 4 | Replayed command |
| tgt_par | output | 1 | Replayed address parity |
| tgt_dphase | output | 1 | Target data phase active |
| tgt_be | output | 4 | Data phase byte enables |
| tgt_last | output | 1 | Final planned data phase |
| tgt_rsp | input | 3 | Target answer: 0 wait, 1 data, 2 disconnect with data, 3 retry, 4 target abort, 5 master abort |
| rd_push | output | 1 | One data transfer for the read data queue |

## Verification
Slot state that has gone wrong shows up at the ports within a single replay. A slot freed too early turns the initiator's next repeat into a fresh `ini_retry` instead of `ini_ack`. A slot left behind makes an extra address phase, or takes capacity that a later read then needs. A wrong write-gating count shows as an address phase that starts too early or never starts, within a few cycles of the deciding `pw_pop`. A wrong replay pointer shows as address phases out of capture order. Byte enable and burst errors are visible on the first wrong data phase.

// File: rtl/drd_pkg.sv
package drd_pkg;

  typedef enum logic [2:0] {
    SL_EMPTY = 3'd0,
    SL_PEND  = 3'd1,
    SL_BUSY  = 3'd2,
    SL_DONE  = 3'd3,
    SL_ERR   = 3'd4
  } slot_st_e;

  typedef enum logic [1:0] {
    RP_IDLE = 2'd0,
    RP_REQ  = 2'd1,
    RP_ADDR = 2'd2,
    RP_DATA = 2'd3
  } rp_st_e;

  localparam logic [2:0] RSP_WAIT  = 3'd0;
  localparam logic [2:0] RSP_DATA  = 3'd1;
  localparam logic [2:0] RSP_DISC  = 3'd2;
  localparam logic [2:0] RSP_RETRY = 3'd3;
  localparam logic [2:0] RSP_TABT  = 3'd4;
  localparam logic [2:0] RSP_MABT  = 3'd5;

  localparam logic [3:0] CMD_IORD  = 4'h2;
  localparam logic [3:0] CMD_MRD   = 4'h6;
  localparam logic [3:0] CMD_CFGRD = 4'hA;
  localparam logic [3:0] CMD_MRM   = 4'hC;
  localparam logic [3:0] CMD_MRL   = 4'hE;

  function automatic logic cmd_is_read(input logic [3:0] c);
    return (c == CMD_IORD) || (c == CMD_MRD) || (c == CMD_CFGRD) ||
           (c == CMD_MRM) || (c == CMD_MRL);
  endfunction

  function automatic logic cmd_is_pref(input logic [3:0] c, input logic space_pref);
    return (c == CMD_MRM) || (c == CMD_MRL) || ((c == CMD_MRD) && space_pref);
  endfunction

endpackage

// File: rtl/drd_capture.sv
module drd_capture
  import drd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ini_start,
  input  logic [AW-1:0] ini_addr,
  input  logic [3:0]    ini_cmd,
  input  logic          ini_par,
  input  logic          ini_pref,
  input  logic          ini_irdy,
  input  logic [3:0]    ini_be,
  output logic          look,
  output logic [AW-1:0] lk_addr,
  output logic [3:0]    lk_cmd,
  output logic          lk_par,
  output logic          lk_pref,
  output logic [3:0]    lk_be
);

  logic          hold_vld_q, hold_vld_d;
  logic [AW-1:0] hold_addr_q;
  logic [3:0]    hold_cmd_q;
  logic          hold_par_q, hold_pref_q;
  logic          load_en;

  assign load_en = ini_start && cmd_is_read(ini_cmd);

  always_comb begin
    hold_vld_d = hold_vld_q;
    if (load_en) begin
      hold_vld_d = 1'b1;
    end else if (ini_irdy) begin
      hold_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
    end else begin
      hold_vld_q <= hold_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      hold_addr_q <= ini_addr;
      hold_cmd_q  <= ini_cmd;
      hold_par_q  <= ini_par;
      hold_pref_q <= cmd_is_pref(ini_cmd, ini_pref);
    end
  end

  assign look    = ini_irdy && hold_vld_q;
  assign lk_addr = hold_addr_q;
  assign lk_cmd  = hold_cmd_q;
  assign lk_par  = hold_par_q;
  assign lk_pref = hold_pref_q;
  assign lk_be   = ini_be;

  AST_LOOK_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    look |-> cmd_is_read(lk_cmd)); // R2

endmodule

// File: rtl/drd_queue.sv
module drd_queue
  import drd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int PWW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          look,
  input  logic [AW-1:0] lk_addr,
  input  logic [3:0]    lk_cmd,
  input  logic          lk_par,
  input  logic          lk_pref,
  input  logic [3:0]    lk_be,
  input  logic          pw_push,
  input  logic          pw_pop,
  input  logic          take,
  input  logic          fin,
  input  logic          fin_err,
  output logic          ini_retry,
  output logic          ini_ack,
  output logic          ini_abort,
  output logic          head_go,
  output logic [AW-1:0] hd_addr,
  output logic [3:0]    hd_cmd,
  output logic          hd_par,
  output logic          hd_pref,
  output logic [3:0]    hd_be
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  slot_st_e      st_q  [DEPTH];
  slot_st_e      st_d  [DEPTH];
  logic [PWW-1:0] wc_q [DEPTH];
  logic [PWW-1:0] wc_d [DEPTH];
  logic [AW-1:0] ad_q  [DEPTH];
  logic [3:0]    cm_q  [DEPTH];
  logic          pa_q  [DEPTH];
  logic          pf_q  [DEPTH];
  logic [3:0]    be_q  [DEPTH];

  logic [IW-1:0]  wp_q, wp_d, rp_q, rp_d, hit_idx;
  logic [PWW-1:0] pw_q, pw_d;
  logic [DEPTH-1:0] hit_v;
  logic hit_any, do_alloc, do_free, pop_ok;
  logic retry_d, ack_d, abort_d;
  slot_st_e hit_st;

  function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] v);
    return (v == IW'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_match
      assign hit_v[gi] = (st_q[gi] != SL_EMPTY) && (ad_q[gi] == lk_addr) &&
                         (cm_q[gi] == lk_cmd);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_v[i]) hit_idx = IW'(i);
    end
  end

  assign hit_any  = |hit_v;
  assign hit_st   = st_q[hit_idx];
  assign do_free  = look && hit_any && ((hit_st == SL_DONE) || (hit_st == SL_ERR));
  assign do_alloc = look && !hit_any && (st_q[wp_q] == SL_EMPTY);
  assign retry_d  = look && !do_free;
  assign ack_d    = do_free;
  assign abort_d  = do_free && (hit_st == SL_ERR);
  assign pop_ok   = pw_pop && (pw_q != '0);
  assign pw_d     = pw_q + PWW'(pw_push) - PWW'(pop_ok);
  assign wp_d     = do_alloc ? ptr_inc(wp_q) : wp_q;
  assign rp_d     = fin ? ptr_inc(rp_q) : rp_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      st_d[i] = st_q[i];
      wc_d[i] = (pop_ok && (wc_q[i] != '0)) ? wc_q[i] - 1'b1 : wc_q[i];
      if (take && (rp_q == IW'(i))) st_d[i] = SL_BUSY;
      if (fin && (rp_q == IW'(i)))  st_d[i] = fin_err ? SL_ERR : SL_DONE;
      if (do_free && (hit_idx == IW'(i))) st_d[i] = SL_EMPTY;
      if (do_alloc && (wp_q == IW'(i))) begin
        st_d[i] = SL_PEND;
        wc_d[i] = pw_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i] <= SL_EMPTY;
        wc_q[i] <= '0;
      end
      wp_q      <= '0;
      rp_q      <= '0;
      pw_q      <= '0;
      ini_retry <= 1'b0;
      ini_ack   <= 1'b0;
      ini_abort <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i] <= st_d[i];
        wc_q[i] <= wc_d[i];
      end
      wp_q      <= wp_d;
      rp_q      <= rp_d;
      pw_q      <= pw_d;
      ini_retry <= retry_d;
      ini_ack   <= ack_d;
      ini_abort <= abort_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_alloc && (wp_q == IW'(i))) begin
        ad_q[i] <= lk_addr;
        cm_q[i] <= lk_cmd;
        pa_q[i] <= lk_par;
        pf_q[i] <= lk_pref;
        be_q[i] <= lk_be;
      end
    end
  end

  assign head_go = (st_q[rp_q] == SL_PEND) && (wc_q[rp_q] == '0);
  assign hd_addr = ad_q[rp_q];
  assign hd_cmd  = cm_q[rp_q];
  assign hd_par  = pa_q[rp_q];
  assign hd_pref = pf_q[rp_q];
  assign hd_be   = be_q[rp_q];

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ini_retry && ini_ack)); // R1
  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((st_q[rp_q] == SL_PEND) && (wc_q[rp_q] == '0))); // R4
  AST_FIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (st_q[rp_q] == SL_BUSY)); // R9
  AST_ABORT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ini_abort |-> ini_ack); // R11
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (look && !hit_any && (st_q[wp_q] != SL_EMPTY)) |=> (wp_q == $past(wp_q))); // R10
  AST_PW_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_push && !pw_pop) |-> (pw_q != '1)); // R4

endmodule

// File: rtl/drd_replay.sv
module drd_replay
  import drd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_go,
  input  logic [AW-1:0] hd_addr,
  input  logic [3:0]    hd_cmd,
  input  logic          hd_par,
  input  logic          hd_pref,
  input  logic [3:0]    hd_be,
  input  logic          tgt_gnt,
  input  logic [2:0]    tgt_rsp,
  output logic          take,
  output logic          fin,
  output logic          fin_err,
  output logic          tgt_req,
  output logic          tgt_addr_vld,
  output logic [AW-1:0] tgt_addr,
  output logic [3:0]    tgt_cmd,
  output logic          tgt_par,
  output logic          tgt_dphase,
  output logic [3:0]    tgt_be,
  output logic          tgt_last,
  output logic          rd_push
);

  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;

  rp_st_e        st_q, st_d;
  logic [BW-1:0] beat_q, beat_d;

  always_comb begin
    st_d         = st_q;
    beat_d       = beat_q;
    take         = 1'b0;
    fin          = 1'b0;
    fin_err      = 1'b0;
    tgt_req      = 1'b0;
    tgt_addr_vld = 1'b0;
    tgt_dphase   = 1'b0;
    tgt_last     = 1'b0;
    rd_push      = 1'b0;
    case (st_q)
      RP_IDLE: begin
        if (head_go) begin
          take = 1'b1;
          st_d = RP_REQ;
        end
      end
      RP_REQ: begin
        tgt_req = 1'b1;
        if (tgt_gnt) st_d = RP_ADDR;
      end
      RP_ADDR: begin
        tgt_addr_vld = 1'b1;
        beat_d       = '0;
        st_d         = RP_DATA;
      end
      RP_DATA: begin
        tgt_dphase = 1'b1;
        tgt_last   = !hd_pref || (beat_q == BW'(BURST - 1));
        case (tgt_rsp)
          RSP_DATA: begin
            rd_push = 1'b1;
            if (tgt_last) begin
              fin  = 1'b1;
              st_d = RP_IDLE;
            end else begin
              beat_d = beat_q + 1'b1;
            end
          end
          RSP_DISC: begin
            rd_push = 1'b1;
            fin     = 1'b1;
            st_d    = RP_IDLE;
          end
          RSP_RETRY: begin
            if (beat_q == '0) begin
              st_d = RP_REQ;
            end else begin
              fin  = 1'b1;
              st_d = RP_IDLE;
            end
          end
          RSP_TABT, RSP_MABT: begin
            fin     = 1'b1;
            fin_err = 1'b1;
            st_d    = RP_IDLE;
          end
          default: st_d = RP_DATA;
        endcase
      end
      default: st_d = RP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RP_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  assign tgt_addr = tgt_addr_vld ? hd_addr : '0;
  assign tgt_cmd  = tgt_addr_vld ? hd_cmd : 4'h0;
  assign tgt_par  = tgt_addr_vld && hd_par;
  assign tgt_be   = (tgt_dphase && !hd_pref) ? hd_be : 4'h0;

  AST_GNT_BEFORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_addr_vld |-> $past(tgt_req && tgt_gnt)); // R5
  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_addr_vld |=> tgt_dphase); // R6
  AST_RETRY_REREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_dphase && (tgt_rsp == RSP_RETRY) && (beat_q == '0)) |=> tgt_req); // R8
  AST_PUSH_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> tgt_dphase); // R9

endmodule

// File: rtl/dly_read_engine.sv
module dly_read_engine
  import drd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int BURST = 4,
  parameter int PWW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ini_start,
  input  logic [AW-1:0] ini_addr,
  input  logic [3:0]    ini_cmd,
  input  logic          ini_par,
  input  logic          ini_pref,
  input  logic          ini_irdy,
  input  logic [3:0]    ini_be,
  output logic          ini_retry,
  output logic          ini_ack,
  output logic          ini_abort,
  input  logic          pw_push,
  input  logic          pw_pop,
  output logic          tgt_req,
  input  logic          tgt_gnt,
  output logic          tgt_addr_vld,
  output logic [AW-1:0] tgt_addr,
  output logic [3:0]    tgt_cmd,
  output logic          tgt_par,
  output logic          tgt_dphase,
  output logic [3:0]    tgt_be,
  output logic          tgt_last,
  input  logic [2:0]    tgt_rsp,
  output logic          rd_push
);

  logic          look, lk_par, lk_pref;
  logic [AW-1:0] lk_addr, hd_addr;
  logic [3:0]    lk_cmd, lk_be, hd_cmd, hd_be;
  logic          head_go, hd_par, hd_pref, take, fin, fin_err;

  drd_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .ini_start(ini_start), .ini_addr(ini_addr),
    .ini_cmd(ini_cmd), .ini_par(ini_par), .ini_pref(ini_pref),
    .ini_irdy(ini_irdy), .ini_be(ini_be), .look(look), .lk_addr(lk_addr),
    .lk_cmd(lk_cmd), .lk_par(lk_par), .lk_pref(lk_pref), .lk_be(lk_be)
  );

  drd_queue #(.AW(AW), .DEPTH(DEPTH), .PWW(PWW)) u_q (
    .clk(clk), .rst_n(rst_n), .look(look), .lk_addr(lk_addr), .lk_cmd(lk_cmd),
    .lk_par(lk_par), .lk_pref(lk_pref), .lk_be(lk_be), .pw_push(pw_push),
    .pw_pop(pw_pop), .take(take), .fin(fin), .fin_err(fin_err),
    .ini_retry(ini_retry), .ini_ack(ini_ack), .ini_abort(ini_abort),
    .head_go(head_go), .hd_addr(hd_addr), .hd_cmd(hd_cmd), .hd_par(hd_par),
    .hd_pref(hd_pref), .hd_be(hd_be)
  );

  drd_replay #(.AW(AW), .BURST(BURST)) u_rp (
    .clk(clk), .rst_n(rst_n), .head_go(head_go), .hd_addr(hd_addr),
    .hd_cmd(hd_cmd), .hd_par(hd_par), .hd_pref(hd_pref), .hd_be(hd_be),
    .tgt_gnt(tgt_gnt), .tgt_rsp(tgt_rsp), .take(take), .fin(fin),
    .fin_err(fin_err), .tgt_req(tgt_req), .tgt_addr_vld(tgt_addr_vld),
    .tgt_addr(tgt_addr), .tgt_cmd(tgt_cmd), .tgt_par(tgt_par),
    .tgt_dphase(tgt_dphase), .tgt_be(tgt_be), .tgt_last(tgt_last),
    .rd_push(rd_push)
  );

endmodule

// File: tb/dly_read_engine_test.sv
module dly_read_engine_test;
  localparam int CLK_PER = 10;
  localparam int AW = 32;
  localparam int BURST = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ini_start, ini_par, ini_pref, ini_irdy;
  logic [AW-1:0] ini_addr;
  logic [3:0] ini_cmd, ini_be;
  logic ini_retry, ini_ack, ini_abort;
  logic pw_push, pw_pop, tgt_req, tgt_gnt, tgt_addr_vld, tgt_par;
  logic tgt_dphase, tgt_last, rd_push;
  logic [AW-1:0] tgt_addr;
  logic [3:0] tgt_cmd, tgt_be;
  logic [2:0] tgt_rsp;

  always #(CLK_PER/2) clk = ~clk;

  dly_read_engine #(.AW(AW), .DEPTH(4), .BURST(BURST), .PWW(4)) uut (
    .clk(clk), .rst_n(rst_n), .ini_start(ini_start), .ini_addr(ini_addr),
    .ini_cmd(ini_cmd), .ini_par(ini_par), .ini_pref(ini_pref),
    .ini_irdy(ini_irdy), .ini_be(ini_be), .ini_retry(ini_retry),
    .ini_ack(ini_ack), .ini_abort(ini_abort), .pw_push(pw_push),
    .pw_pop(pw_pop), .tgt_req(tgt_req), .tgt_gnt(tgt_gnt),
    .tgt_addr_vld(tgt_addr_vld), .tgt_addr(tgt_addr), .tgt_cmd(tgt_cmd),
    .tgt_par(tgt_par), .tgt_dphase(tgt_dphase), .tgt_be(tgt_be),
    .tgt_last(tgt_last), .tgt_rsp(tgt_rsp), .rd_push(rd_push)
  );

  int nchk = 0, nbad = 0, cyc = 0;
  int n_addr, n_dph, n_xfer, n_push, be_bad, last_bad, beat_i, sp, exp_beats;
  logic [3:0] exp_be;
  logic [2:0] script [8];
  logic [AW-1:0] addr_log [64];
  logic [3:0] cmd_log [64];
  logic par_log [64];
  logic r_retry, r_ack, r_abort;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target responder, drives and samples away from the rising edge
  always @(negedge clk) begin
    if (tgt_addr_vld) begin
      addr_log[n_addr % 64] = tgt_addr;
      cmd_log[n_addr % 64]  = tgt_cmd;
      par_log[n_addr % 64]  = tgt_par;
      n_addr++;
      beat_i = 0;
    end
    if (tgt_dphase) begin
      logic [2:0] r;
      if (tgt_be !== exp_be) be_bad++;
      if (tgt_last !== (beat_i == exp_beats - 1)) last_bad++;
      r = (sp < 8) ? script[sp] : 3'd1;
      sp++;
      n_dph++;
      tgt_rsp = r;
      if (r == 3'd1 || r == 3'd2) begin
        n_xfer++;
        beat_i++;
      end
    end else begin
      tgt_rsp = 3'd0;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rd_push) n_push++;
  end

  task automatic clear(input logic [3:0] be, input int beats);
    n_addr = 0; n_dph = 0; n_xfer = 0; n_push = 0; be_bad = 0; last_bad = 0;
    beat_i = 0; sp = 0; exp_be = be; exp_beats = beats;
    for (int i = 0; i < 8; i++) script[i] = 3'd1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [3:0] c,
                         input logic p, input logic [3:0] be, input logic pf);
    @(negedge clk);
    ini_start = 1'b1; ini_addr = a; ini_cmd = c; ini_par = p; ini_pref = pf;
    @(negedge clk);
    ini_start = 1'b0; ini_irdy = 1'b1; ini_be = be;
    @(negedge clk);
    ini_irdy = 1'b0;
    r_retry = ini_retry; r_ack = ini_ack; r_abort = ini_abort;
  endtask

  task automatic pulse_push();
    @(negedge clk); pw_push = 1'b1; @(negedge clk); pw_push = 1'b0;
  endtask

  task automatic pulse_pop();
    @(negedge clk); pw_pop = 1'b1; @(negedge clk); pw_pop = 1'b0;
  endtask

  task automatic deliver(input string req, input logic [AW-1:0] a,
                         input logic [3:0] c, input logic exp_abort);
    do_read(a, c, 1'b0, 4'h0, 1'b0);
    check(req, {r_ack, r_retry, r_abort}, {1'b1, 1'b0, exp_abort});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] rdc [5];
    logic [AW-1:0] ba [5];
    rdc[0] = 4'h2; rdc[1] = 4'h6; rdc[2] = 4'hA; rdc[3] = 4'hC; rdc[4] = 4'hE;
    rst_n = 1'b0; ini_start = 0; ini_irdy = 0; ini_addr = '0; ini_cmd = 0;
    ini_par = 0; ini_pref = 0; ini_be = 0; pw_push = 0; pw_pop = 0;
    tgt_gnt = 1'b1; tgt_rsp = 3'd0;
    clear(4'h0, 1);
    settle(3);
    rst_n = 1'b1;
    settle(1);
    check("R1 reset retry", ini_retry, 0);
    check("R5 reset req", {tgt_req, tgt_addr_vld, tgt_dphase}, 0);

    // R5: request held until grant
    tgt_gnt = 1'b0;
    clear(4'h5, 1);
    do_read(32'h0000_4000, 4'h6, 1'b1, 4'h5, 1'b0);
    check("R1 first retry", r_retry, 1);
    settle(6);
    check("R5 req held", tgt_req, 1);
    check("R5 no addr before grant", n_addr, 0);
    tgt_gnt = 1'b1;
    settle(8);
    check("R5 one address phase", n_addr, 1);
    check("R5 parity replay", par_log[0], 1);
    deliver("R9 ack after grant", 32'h0000_4000, 4'h6, 1'b0);

    // R1 R5 R6 R7 R9 R13: sweep read commands and prefetch hint
    for (int c = 0; c < 5; c++) begin
      for (int pf = 0; pf < 2; pf++) begin
        logic pref;
        logic [AW-1:0] a;
        logic [3:0] be;
        pref = (rdc[c] == 4'hC) || (rdc[c] == 4'hE) || (rdc[c] == 4'h6 && pf == 1);
        a = 32'h1000_0000 + 32'(c * 64 + pf * 8);
        be = 4'(3 + c * 2 + pf);
        clear(pref ? 4'h0 : be, pref ? BURST : 1);
        do_read(a, rdc[c], 1'((c + pf) & 1), be, 1'(pf));
        check("R1 capture retry", {r_retry, r_ack}, 2'b10);
        settle(12);
        check("R5 addr count", n_addr, 1);
        check("R5 addr", int'(addr_log[0] == a), 1);
        check("R5 cmd", cmd_log[0], rdc[c]);
        check("R5 par", par_log[0], (c + pf) & 1);
        check(pref ? "R7 beats" : "R6 beats", n_dph, pref ? BURST : 1);
        check(pref ? "R7 be" : "R6 be", be_bad, 0);
        check(pref ? "R7 last" : "R6 last", last_bad, 0);
        check("R9 rd_push count", n_push, pref ? BURST : 1);
        deliver("R9 ack", a, rdc[c], 1'b0);
        do_read(a, rdc[c], 1'b0, be, 1'(pf));
        check("R13 recaptured", {r_retry, r_ack}, 2'b10);
        settle(12);
        deliver("R13 ack again", a, rdc[c], 1'b0);
      end
    end

    // R2: every non-read code ignored
    for (int k = 0; k < 16; k++) begin
      logic is_rd;
      is_rd = (k == 2) || (k == 6) || (k == 10) || (k == 12) || (k == 14);
      if (!is_rd) begin
        clear(4'h0, 1);
        do_read(32'h2000_0000 + 32'(k), 4'(k), 1'b0, 4'hF, 1'b0);
        settle(1);
        check("R2 no response", {r_retry, r_ack, ini_retry, ini_ack}, 0);
        settle(6);
        check("R2 no replay", n_addr, 0);
      end
    end

    // R8: retries before data repeat the read
    clear(4'h9, 1);
    script[0] = 3'd3; script[1] = 3'd3; script[2] = 3'd0; script[3] = 3'd1;
    do_read(32'h3000_0010, 4'h6, 1'b0, 4'h9, 1'b0);
    settle(20);
    check("R8 attempts", n_addr, 3);
    check("R8 one transfer", n_push, 1);
    check("R8 be each attempt", be_bad, 0);
    deliver("R8 ack", 32'h3000_0010, 4'h6, 1'b0);

    // R9: disconnect with data ends the burst
    clear(4'h0, BURST);
    script[0] = 3'd1; script[1] = 3'd2;
    do_read(32'h3000_0100, 4'hC, 1'b0, 4'h3, 1'b0);
    settle(16);
    check("R9 disconnect attempts", n_addr, 1);
    check("R9 disconnect pushes", n_push, 2);
    deliver("R9 disconnect ack", 32'h3000_0100, 4'hC, 1'b0);

    // R9: retry after one transfer ends without another attempt
    clear(4'h0, BURST);
    script[0] = 3'd1; script[1] = 3'd3;
    do_read(32'h3000_0200, 4'hE, 1'b0, 4'h3, 1'b0);
    settle(16);
    check("R9 late retry attempts", n_addr, 1);
    check("R9 late retry pushes", n_push, 1);
    deliver("R9 late retry ack", 32'h3000_0200, 4'hE, 1'b0);

    // R11: target abort and master abort
    for (int e = 0; e < 2; e++) begin
      clear(4'h6, 1);
      script[0] = (e == 0) ? 3'd4 : 3'd5;
      do_read(32'h3000_0300 + 32'(e * 4), 4'h6, 1'b0, 4'h6, 1'b0);
      settle(10);
      check("R11 abort no data", n_push, 0);
      deliver("R11 abort ack", 32'h3000_0300 + 32'(e * 4), 4'h6, 1'b1);
      do_read(32'h3000_0300 + 32'(e * 4), 4'h6, 1'b0, 4'h6, 1'b0);
      check("R13 freed after abort", {r_retry, r_ack}, 2'b10);
      settle(10);
      deliver("R11 rerun ack", 32'h3000_0300 + 32'(e * 4), 4'h6, 1'b0);
    end

    // R4: gating by earlier posted writes only
    clear(4'h1, 1);
    pulse_push(); pulse_push();
    do_read(32'h4000_0000, 4'h6, 1'b0, 4'h1, 1'b0);
    settle(10);
    check("R4 held by two writes", n_addr, 0);
    pulse_push();
    pulse_pop();
    settle(8);
    check("R4 held by one write", n_addr, 0);
    pulse_pop();
    settle(10);
    check("R4 released by last earlier write", n_addr, 1);
    pulse_pop();
    deliver("R4 ack", 32'h4000_0000, 4'h6, 1'b0);

    // R3 R10 R12: fill, duplicate, overflow, order
    clear(4'h2, 1);
    for (int i = 0; i < 5; i++) ba[i] = 32'h5000_0000 + 32'(i * 16);
    pulse_push();
    for (int i = 0; i < 4; i++) begin
      do_read(ba[i], 4'h6, 1'b0, 4'h2, 1'b0);
      check("R1 fill retry", {r_retry, r_ack}, 2'b10);
    end
    do_read(ba[1], 4'h6, 1'b0, 4'h2, 1'b0);
    check("R3 duplicate retry", {r_retry, r_ack}, 2'b10);
    do_read(ba[4], 4'h6, 1'b0, 4'h2, 1'b0);
    check("R10 full retry", {r_retry, r_ack}, 2'b10);
    pulse_pop();
    settle(30);
    check("R3 R10 replay count", n_addr, 4);
    for (int i = 0; i < 4; i++) check("R12 order", int'(addr_log[i] == ba[i]), 1);
    do_read(ba[4], 4'h6, 1'b0, 4'h2, 1'b0);
    check("R10 still full", {r_retry, r_ack}, 2'b10);
    settle(10);
    check("R10 not captured", n_addr, 4);
    for (int i = 0; i < 4; i++) deliver("R9 drain ack", ba[i], 4'h6, 1'b0);
    do_read(ba[4], 4'h6, 1'b0, 4'h2, 1'b0);
    check("R10 captured after drain", {r_retry, r_ack}, 2'b10);
    settle(10);
    check("R10 replay after drain", n_addr, 5);
    deliver("R10 final ack", ba[4], 4'h6, 1'b0);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule